// File: doc/BRIEF.md
# Transaction Word-Update Packing Buffer

This block is the per-core staging buffer of a persistent-memory controller. While a transaction is open it accepts single 64-bit word writes, each tagged with a 40-bit home-region word offset. It gathers them into a 128-byte slice: one 64-byte line of packed data words, and one 64-byte line of packed metadata. The metadata line holds the home offsets, the transaction identifier, a first-slice marker, a fill count, close-reason flags and a next-slice pointer. The slice leaves on the log write port as two back-to-back 512-bit beats, data line first.

A slice is closed as soon as its eighth distinct word is accepted, or at once when the transaction ends with at least one word held. A second write to a word offset that already sits in the open slice replaces the held data and takes no new slot. Each core owns one instance, so transactions on different cores never share it. Word writes use a valid/ready handshake, and ready drops while a slice is on its way out. Choosing log addresses, tracking mappings and reclaiming space are handled elsewhere. The next-slice pointer is supplied from outside.

Top module: `upb_pack_buffer`

## Requirements
- R1: In the first beat (outLast low), held word k sits at outData[64k+63:64k], in order of first acceptance; bits of unfilled slots are zero.
- R2: In the second beat (outLast high), the home offset of slot k sits at outData[40k+39:40k] (unfilled slots zero), the transaction ID latched at txBegin sits at [351:320], and [511:384] are zero.
- R3: A slice is sent as exactly two consecutive cycles with outValid high, outLast low then high; outData is zero whenever outValid is low.
- R4: When a write of an eighth distinct offset is accepted, the data beat appears in the following cycle.
- R5: A txEnd while words are held starts the data beat in the following cycle; a txEnd with nothing held sends nothing and closes the transaction.
- R6: A write whose offset equals a held offset overwrites that slot's data and does not raise the count.
- R7: The count field [355:353] is the number of held words minus one; the start bit [352] is 1 only in the first slice of a transaction.
- R8: Flag field [359:356]: bit 356 is set when txEnd closed the slice, bit 357 when the slice held eight words; bits 358 and 359 are zero.
- R9: The next-slice field [383:360] equals nextSlicePtr during the second beat.
- R10: wrReady is high only while a transaction is open and no slice is being sent; after a fill flush that leaves the transaction open, it returns in the cycle after the second beat.
- R11: txBegin is ignored while a transaction is open or a slice is being sent, and writes offered with no open transaction are not accepted.
- R12: During reset outValid and wrReady are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txBegin | input | 1 | Open-transaction pulse |
| txEnd | input | 1 | Close-transaction pulse |
| txIdIn | input | 32 | Transaction ID, sampled with txBegin |
| wrValid | input | 1 | Word write offered |
| wrReady | output | 1 | Word write can be taken this cycle |
| wrAddr | input | 40 | Home-region word offset of the write |
| wrData | input | 64 | Word data |
| nextSlicePtr | input | 24 | Pointer placed in the metadata beat |
| outValid | output | 1 | A slice beat is on outData |
| outLast | output | 1 | Current beat is the metadata line |
| outData | output | 512 | Beat contents |

## Verification
The hardest situation to reach is a slice closed by a fill and a transaction end in the same cycle. Here both flag bits must be set and the transaction must close without an empty trailing slice. The stimulus raises txEnd together with the eighth distinct write. Repeated offsets inside a slice come from a scenario that writes a small address pool with fixed and pseudo-random picks, so overwrites land in slots other than slot zero. A reference model checks every cycle.

// File: rtl/upb_pkg.sv
package upb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OPEN  = 2'd1,
    ST_BEAT0 = 2'd2,
    ST_BEAT1 = 2'd3
  } upbState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic acceptWr;    // word write taken this cycle
    logic startTx;     // transaction opens, latch ID
    logic clearSlice;  // slice sent, empty it
    logic emitData;    // drive data line
    logic emitMeta;    // drive metadata line
    logic endFlag;     // slice closed by transaction end
    logic fillFlag;    // slice closed full
  } upbStrobes_t;

endpackage

// File: rtl/upb_ctrl.sv
module upb_ctrl
  import upb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        txBegin,
  input  logic        txEnd,
  input  logic        wrValid,
  input  logic        fillOnAccept,
  input  logic        sliceEmpty,
  output logic        wrReady,
  output upbStrobes_t strobes
);

  upbState_t state, stateNxt;
  logic endFlagQ, fillFlagQ, lateEndQ;
  logic accept, goFlush;

  always_comb begin
    wrReady = (state == ST_OPEN);
    accept  = wrReady && wrValid;
    goFlush = (state == ST_OPEN) &&
              ((accept && fillOnAccept) || (txEnd && (accept || !sliceEmpty)));

    strobes.acceptWr   = accept;
    strobes.startTx    = (state == ST_IDLE) && txBegin;
    strobes.clearSlice = (state == ST_BEAT1);
    strobes.emitData   = (state == ST_BEAT0);
    strobes.emitMeta   = (state == ST_BEAT1);
    strobes.endFlag    = endFlagQ;
    strobes.fillFlag   = fillFlagQ;
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:  if (txBegin) stateNxt = ST_OPEN;
      ST_OPEN: begin
        if (goFlush)    stateNxt = ST_BEAT0;
        else if (txEnd) stateNxt = ST_IDLE;
      end
      ST_BEAT0: stateNxt = ST_BEAT1;
      ST_BEAT1: stateNxt = (lateEndQ || txEnd || endFlagQ) ? ST_IDLE : ST_OPEN;
      default:  stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      endFlagQ  <= 1'b0;
      fillFlagQ <= 1'b0;
      lateEndQ  <= 1'b0;
    end else begin
      state <= stateNxt;
      if (goFlush) begin
        endFlagQ  <= txEnd;
        fillFlagQ <= accept && fillOnAccept;
      end
      if (state == ST_BEAT0) lateEndQ <= lateEndQ || txEnd;
      if (state == ST_BEAT1) lateEndQ <= 1'b0;
    end
  end

endmodule

// File: rtl/upb_datapath.sv
module upb_datapath
  import upb_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int DATA_W = 64,
  parameter int ADDR_W = 40,
  parameter int TXID_W = 32,
  parameter int PTR_W  = 24,
  parameter int BEAT_W = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  upbStrobes_t       strobes,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [TXID_W-1:0] txIdIn,
  input  logic [PTR_W-1:0]  nextSlicePtr,
  output logic              fillOnAccept,
  output logic              sliceEmpty,
  output logic [BEAT_W-1:0] beatData
);

  localparam int CNT_W     = $clog2(SLOTS);
  localparam int CNT_BITS  = CNT_W + 1;
  localparam int FLAG_W    = 4;
  localparam int TXID_LSB  = SLOTS * ADDR_W;
  localparam int START_BIT = TXID_LSB + TXID_W;
  localparam int CNT_LSB   = START_BIT + 1;
  localparam int FLAG_LSB  = CNT_LSB + CNT_W;
  localparam int PTR_LSB   = FLAG_LSB + FLAG_W;

  logic [DATA_W-1:0]   slotData [SLOTS];
  logic [ADDR_W-1:0]   slotAddr [SLOTS];
  logic [CNT_BITS-1:0] count;
  logic [CNT_BITS-1:0] cntMinus;
  logic                firstQ;
  logic [TXID_W-1:0]   txIdQ;
  logic [SLOTS-1:0]    hitVec;
  logic                anyHit;
  logic [CNT_W-1:0]    hitIdx;
  logic [CNT_W-1:0]    writeIdx;
  logic [BEAT_W-1:0]   dataLine, metaLine;

  // offset match against every held slot
  for (genvar g = 0; g < SLOTS; g++) begin : gMatch
    assign hitVec[g] = (CNT_BITS'(g) < count) && (slotAddr[g] == wrAddr);
  end

  always_comb begin
    hitIdx = '0;
    for (int i = 0; i < SLOTS; i++)
      if (hitVec[i]) hitIdx = CNT_W'(i);
  end

  assign anyHit       = |hitVec;
  assign writeIdx     = anyHit ? hitIdx : count[CNT_W-1:0];
  assign fillOnAccept = !anyHit && (count == CNT_BITS'(SLOTS - 1));
  assign sliceEmpty   = (count == '0);
  assign cntMinus     = count - CNT_BITS'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count  <= '0;
      firstQ <= 1'b0;
      txIdQ  <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        slotData[i] <= '0;
        slotAddr[i] <= '0;
      end
    end else begin
      if (strobes.startTx) begin
        txIdQ  <= txIdIn;
        firstQ <= 1'b1;
        count  <= '0;
      end else if (strobes.clearSlice) begin
        count  <= '0;
        firstQ <= 1'b0;
      end else if (strobes.acceptWr && !anyHit) begin
        count <= count + CNT_BITS'(1);
      end
      if (strobes.acceptWr) begin
        for (int i = 0; i < SLOTS; i++) begin
          if (writeIdx == CNT_W'(i)) begin
            slotData[i] <= wrData;
            slotAddr[i] <= wrAddr;
          end
        end
      end
    end
  end

  always_comb begin
    dataLine = '0;
    metaLine = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (CNT_BITS'(i) < count) begin
        dataLine[i*DATA_W +: DATA_W] = slotData[i];
        metaLine[i*ADDR_W +: ADDR_W] = slotAddr[i];
      end
    end
    metaLine[TXID_LSB +: TXID_W] = txIdQ;
    metaLine[START_BIT]          = firstQ;
    metaLine[CNT_LSB +: CNT_W]   = cntMinus[CNT_W-1:0];
    metaLine[FLAG_LSB]           = strobes.endFlag;
    metaLine[FLAG_LSB + 1]       = strobes.fillFlag;
    metaLine[PTR_LSB +: PTR_W]   = nextSlicePtr;
  end

  always_comb begin
    if (strobes.emitMeta)      beatData = metaLine;
    else if (strobes.emitData) beatData = dataLine;
    else                       beatData = '0;
  end

endmodule

// File: rtl/upb_pack_buffer.sv
module upb_pack_buffer
  import upb_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int DATA_W = 64,
  parameter int ADDR_W = 40,
  parameter int TXID_W = 32,
  parameter int PTR_W  = 24,
  parameter int BEAT_W = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txBegin,
  input  logic              txEnd,
  input  logic [TXID_W-1:0] txIdIn,
  input  logic              wrValid,
  output logic              wrReady,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [PTR_W-1:0]  nextSlicePtr,
  output logic              outValid,
  output logic              outLast,
  output logic [BEAT_W-1:0] outData
);

  upbStrobes_t strobes;
  logic fillOnAccept, sliceEmpty;

  upb_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .txBegin(txBegin), .txEnd(txEnd),
    .wrValid(wrValid), .fillOnAccept(fillOnAccept), .sliceEmpty(sliceEmpty),
    .wrReady(wrReady), .strobes(strobes)
  );

  upb_datapath #(
    .SLOTS(SLOTS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .TXID_W(TXID_W), .PTR_W(PTR_W), .BEAT_W(BEAT_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrAddr(wrAddr),
    .wrData(wrData), .txIdIn(txIdIn), .nextSlicePtr(nextSlicePtr),
    .fillOnAccept(fillOnAccept), .sliceEmpty(sliceEmpty), .beatData(outData)
  );

  assign outValid = strobes.emitData || strobes.emitMeta;
  assign outLast  = strobes.emitMeta;

endmodule

// File: rtl/upb_pack_buffer_chk.sv
module upb_pack_buffer_chk #(
  parameter int BEAT_W  = 512,
  parameter int PAD_LSB = 384
) (
  input logic              clk,
  input logic              rstN,
  input logic              txBegin,
  input logic              wrReady,
  input logic              outValid,
  input logic              outLast,
  input logic [BEAT_W-1:0] outData
);

  // R3
  beat_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outLast) |=> (outValid && outLast));

  // R3
  beat_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outLast) |=> !outValid);

  // R10
  ready_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !wrReady);

  // R10
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrReady) |-> ($past(txBegin) || $past(outLast)));

  // R2
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outLast) |-> (outData[BEAT_W-1:PAD_LSB] == '0));

  // R3
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (outData == '0));

endmodule

bind upb_pack_buffer upb_pack_buffer_chk #(.BEAT_W(BEAT_W)) uChk (
  .clk(clk), .rstN(rstN), .txBegin(txBegin), .wrReady(wrReady),
  .outValid(outValid), .outLast(outLast), .outData(outData)
);

// File: tb/tb_upb_pack_buffer.sv
`timescale 1ns/1ps
module tb_upb_pack_buffer;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         txBegin = 1'b0, txEnd = 1'b0, wrValid = 1'b0;
  logic [31:0]  txIdIn = '0;
  logic [39:0]  wrAddr = '0;
  logic [63:0]  wrData = '0;
  logic [23:0]  nextSlicePtr = '0;
  logic         wrReady, outValid, outLast;
  logic [511:0] outData;

  int nChecks = 0;
  int nErr = 0;

  always #10 clk = ~clk;  // 50 MHz

  upb_pack_buffer dut (
    .clk(clk), .rstN(rstN), .txBegin(txBegin), .txEnd(txEnd), .txIdIn(txIdIn),
    .wrValid(wrValid), .wrReady(wrReady), .wrAddr(wrAddr), .wrData(wrData),
    .nextSlicePtr(nextSlicePtr), .outValid(outValid), .outLast(outLast),
    .outData(outData)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [511:0] act, input logic [511:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int          mState = 0;  // 0 idle, 1 open, 2 data beat, 3 meta beat
  logic [63:0] mData [8];
  logic [39:0] mAddr [8];
  int          mN = 0;
  logic [31:0] mTx = '0;
  bit          mFirst = 0, mEnd = 0, mFill = 0, mLate = 0;
  logic [511:0] lastMeta = '0, lastData = '0;

  task automatic modelStep();
    int hit;
    bit acc;
    if (!rstN) begin
      mState = 0; mN = 0; mFirst = 0; mEnd = 0; mFill = 0; mLate = 0; mTx = '0;
      return;
    end
    case (mState)
      0: if (txBegin) begin mState = 1; mTx = txIdIn; mFirst = 1; mN = 0; end
      1: begin
        acc = wrValid;
        if (acc) begin
          hit = -1;
          for (int k = 0; k < mN; k++) if (mAddr[k] == wrAddr) hit = k;
          if (hit >= 0) mData[hit] = wrData;
          else begin mData[mN] = wrData; mAddr[mN] = wrAddr; mN++; end
        end
        if ((acc && mN == 8) || (txEnd && mN > 0)) begin
          mState = 2; mEnd = txEnd; mFill = (mN == 8);
        end else if (txEnd) mState = 0;
      end
      2: begin if (txEnd) mLate = 1; mState = 3; end
      default: begin
        mState = (mLate || txEnd || mEnd) ? 0 : 1;
        mN = 0; mFirst = 0; mLate = 0;
      end
    endcase
  endtask

  function automatic logic [511:0] expBeat();
    logic [511:0] b = '0;
    if (mState == 2) begin
      for (int k = 0; k < mN; k++) b[k*64 +: 64] = mData[k];
    end else if (mState == 3) begin
      for (int k = 0; k < mN; k++) b[k*40 +: 40] = mAddr[k];
      b[351:320] = mTx;
      b[352]     = mFirst;
      b[355:353] = 3'(mN - 1);
      b[356]     = mEnd;
      b[357]     = mFill;
      b[383:360] = nextSlicePtr;
    end
    return b;
  endfunction

  always @(posedge clk) begin
    logic [511:0] e;
    modelStep();
    #5;
    if (rstN) begin
      e = expBeat();
      chk(wrReady == (mState == 1), "R10 wrReady", 512'(wrReady), 512'(mState == 1));
      chk(outValid == (mState >= 2) && outLast == (mState == 3), "R3 beat strobes",
          {outValid, outLast}, {mState >= 2, mState == 3});
      if (mState == 2) chk(outData == e, "R1 data line", outData, e);
      else if (mState == 3) begin
        chk(outData[351:0] == e[351:0], "R2 offsets and txid", outData[351:0], e[351:0]);
        chk(outData[355:352] == e[355:352], "R7 count and start", outData[355:352], e[355:352]);
        chk(outData[359:356] == e[359:356], "R8 flags", outData[359:356], e[359:356]);
        chk(outData[383:360] == e[383:360], "R9 next pointer", outData[383:360], e[383:360]);
        chk(outData[511:384] == '0, "R2 padding", outData[511:384], '0);
      end else chk(outData == '0, "R3 idle data zero", outData, '0);
      if (outValid && outLast) lastMeta = outData;
      if (outValid && !outLast) lastData = outData;
    end
  end

  // ---------------- stimulus helpers (called at a negedge) ----------------
  task automatic beginTx(input logic [31:0] id);
    txBegin = 1'b1; txIdIn = id;
    @(negedge clk);
    txBegin = 1'b0;
  endtask

  task automatic endTx();
    txEnd = 1'b1;
    @(negedge clk);
    txEnd = 1'b0;
  endtask

  task automatic doWrite(input logic [39:0] a, input logic [63:0] d, input bit withEnd);
    while (!wrReady) @(negedge clk);
    wrValid = 1'b1; wrAddr = a; wrData = d; txEnd = withEnd;
    @(negedge clk);
    wrValid = 1'b0; txEnd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      nextSlicePtr = nextSlicePtr + 24'h01357b;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nErr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!outValid && !wrReady, "R12 reset outputs", {outValid, wrReady}, 2'b00);
    rstN = 1'b1;
    @(negedge clk);

    // partial slice closed by txEnd
    beginTx(32'hA1A1_0001);
    doWrite(40'h10_0000_0008, 64'h1111_0000_0000_0001, 0);
    doWrite(40'h20_0000_0010, 64'h2222_0000_0000_0002, 0);
    doWrite(40'h30_0000_0018, 64'h3333_0000_0000_0003, 0);
    endTx();
    chk(outValid && !outLast, "R5 partial flush starts", {outValid, outLast}, 2'b10);
    idle(4);
    chk(lastMeta[355:353] == 3'd2, "R7 count minus one", lastMeta[355:353], 3'd2);
    chk(lastMeta[352] == 1'b1, "R7 start bit first slice", lastMeta[352], 1'b1);
    chk(lastMeta[359:356] == 4'b0001, "R8 end flag", lastMeta[359:356], 4'b0001);

    // fill flush then a second slice; txBegin ignored mid-transaction
    beginTx(32'hB1B1_0002);
    for (int k = 0; k < 8; k++) doWrite(40'(64'h100 + k * 8), 64'hB000 + 64'(k), 0);
    chk(outValid && !outLast, "R4 fill flush next cycle", {outValid, outLast}, 2'b10);
    chk(!wrReady, "R10 ready low during flush", wrReady, 1'b0);
    txBegin = 1'b1; txIdIn = 32'hC3C3_0003;
    @(negedge clk);
    txBegin = 1'b0;
    chk(!wrReady && outLast, "R10 still flushing on meta beat", {wrReady, outLast}, 2'b01);
    @(negedge clk);
    chk(wrReady, "R10 ready back after meta beat", wrReady, 1'b1);
    doWrite(40'h900, 64'hB009, 0);
    beginTx(32'hC4C4_0004);
    doWrite(40'h908, 64'hB00A, 0);
    endTx();
    idle(4);
    chk(lastMeta[351:320] == 32'hB1B1_0002, "R11 txBegin ignored, id kept",
        lastMeta[351:320], 32'hB1B1_0002);
    chk(lastMeta[352] == 1'b0, "R7 start bit clear on later slice", lastMeta[352], 1'b0);
    chk(lastMeta[355:353] == 3'd1, "R7 second slice count", lastMeta[355:353], 3'd1);

    // overwrite in place
    beginTx(32'hD1D1_0005);
    doWrite(40'h5000, 64'hD1, 0);
    doWrite(40'h5008, 64'hD2, 0);
    doWrite(40'h5000, 64'hD3, 0);
    endTx();
    idle(4);
    chk(lastMeta[355:353] == 3'd1, "R6 overwrite takes no slot", lastMeta[355:353], 3'd1);
    chk(lastData[63:0] == 64'hD3, "R6 overwrite data", lastData[63:0], 64'hD3);
    chk(lastData[191:128] == '0, "R1 unused slot zero", lastData[191:128], '0);

    // empty transaction
    beginTx(32'hE1E1_0006);
    endTx();
    chk(!outValid && !wrReady, "R5 empty end sends nothing", {outValid, wrReady}, 2'b00);
    idle(2);
    chk(!outValid, "R5 still nothing sent", outValid, 1'b0);

    // writes offered with no transaction
    wrValid = 1'b1; wrAddr = 40'h7777; wrData = 64'h77;
    repeat (3) begin
      @(negedge clk);
      chk(!wrReady && !outValid, "R11 idle write not taken", {wrReady, outValid}, 2'b00);
    end
    wrValid = 1'b0;

    // fill and end in the same cycle
    beginTx(32'hF1F1_0007);
    for (int k = 0; k < 7; k++) doWrite(40'(64'h2000 + k * 8), 64'hF0 + 64'(k), 0);
    doWrite(40'h2100, 64'hFF, 1);
    idle(4);
    chk(lastMeta[359:356] == 4'b0011, "R8 fill and end flags", lastMeta[359:356], 4'b0011);
    chk(!wrReady, "R5 transaction closed after fill-end", wrReady, 1'b0);

    // mixed pool with repeats
    beginTx(32'h0A0A_0008);
    for (int k = 0; k < 20; k++)
      doWrite(40'(64'h3000 + 8 * ((k * 3) % 5)), 64'(k) + 64'(($urandom % 16) << 8), 0);
    for (int k = 0; k < 12; k++)
      doWrite(40'(64'h4000 + 8 * ($urandom % 11)), 64'hA000 + 64'(k), 0);
    endTx();
    idle(6);

    summary();
    $finish;
  end

endmodule